// File: doc/BRIEF.md
# Rename Map with Inlined Narrow Values

This block is the register rename map of an out-of-order integer core. It is a table indexed directly by logical register number, with 32 entries. Each entry holds one of two things. It can hold a pointer to the physical register that will carry the logical register's value. It can also hold the value itself, when that value is small enough to fit in the entry. Storing a small value in the entry lets its physical register go back to the free pool long before the next writer of the logical register commits.

The rename stage uses one port. In a cycle it looks up two source registers and maps one destination to a newly allocated physical tag. A source that finds a stored value receives that value as a full 32-bit operand, sign-extended from 7 bits, together with an immediate flag, in place of a tag.

The writeback stage uses the other port. It presents a 7-bit narrow result with the logical register and the physical tag it was produced for. The entry changes from pointer to stored value only if it still points at that tag. A register that was renamed again in the meantime keeps its newer mapping. When the write is accepted, the block reports the physical tag as released. Checkpointing, the free list and the narrowness test on ALU results sit outside this block.

Top module: `rename_inline_map`

## Requirements
- R1: After reset, every logical register i reads as a pointer to physical tag i: imm flag 0, tag i, value 0.
- R2: A rename write of tag t to logical register d makes later reads of d return imm 0 and tag t, from the cycle after the write edge.
- R3: A source read in the same cycle as a rename write to that register returns the contents from before the write.
- R4: A writeback for register r with tag p and 7-bit value v is accepted when the entry of r is a pointer whose tag equals p. From the next cycle, reads of r return imm 1, tag 0 and v in value bits 6:0.
- R5: An inlined operand is the sign extension of its 7-bit payload: value bits 31:7 all equal payload bit 6.
- R6: A pointer read returns imm 0, value 0, and the stored 6-bit tag on the tag output.
- R7: A writeback whose tag differs from the tag currently mapped for r is ignored. The entry is unchanged and no release is reported.
- R8: A writeback to an entry that already holds a stored value is ignored, even when the low 6 bits of the stored value equal the writeback tag.
- R9: When a rename write and a writeback target the same logical register in one cycle, the rename write takes effect and the writeback is ignored with no release.
- R10: An accepted writeback raises rel_valid for exactly one cycle after the accepting edge, with rel_tag equal to the writeback tag.
- R11: A rename write to a register holding a stored value turns the entry back into a pointer to the new tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_src0 | input | 5 | Logical register of source 0 |
| ren_src1 | input | 5 | Logical register of source 1 |
| ren_we | input | 1 | Rename write enable |
| ren_dst | input | 5 | Logical destination register |
| ren_tag | input | 6 | Newly allocated physical tag for the destination |
| wb_valid | input | 1 | Narrow writeback present |
| wb_lreg | input | 5 | Logical register of the narrow result |
| wb_ptag | input | 6 | Physical tag the result was produced for |
| wb_value | input | 7 | 7-bit narrow result |
| src0_imm | output | 1 | Source 0 is an inlined value |
| src0_tag | output | 6 | Source 0 physical tag (0 when inlined) |
| src0_val | output | 32 | Source 0 sign-extended value (0 when a pointer) |
| src1_imm | output | 1 | Source 1 is an inlined value |
| src1_tag | output | 6 | Source 1 physical tag (0 when inlined) |
| src1_val | output | 32 | Source 1 sign-extended value (0 when a pointer) |
| rel_valid | output | 1 | A physical register is released this cycle |
| rel_tag | output | 6 | Released physical tag |

## Verification
The bench first targets the guard on writebacks. A design that compared only the logical register would overwrite a remapped entry with a stale value and release a tag that is still live. A design that skipped the pointer check on an inlined entry whose payload aliases the tag would release a register twice. The bench also drives a rename and a writeback to the same register in one cycle, where the wrong priority loses the new mapping, and a read that coincides with a rename write, where a bypassing design returns the new tag too early. Negative payloads expose zero extension in place of sign extension.

// File: rtl/rename_inline_map.sv
module rename_inline_map #(
  parameter int NUM_LREGS = 32,
  parameter int TAG_W     = 6,
  parameter int PAYLOAD_W = 7,
  parameter int DATA_W    = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [$clog2(NUM_LREGS)-1:0] ren_src0,
  input  logic [$clog2(NUM_LREGS)-1:0] ren_src1,
  input  logic                         ren_we,
  input  logic [$clog2(NUM_LREGS)-1:0] ren_dst,
  input  logic [TAG_W-1:0]             ren_tag,
  input  logic                         wb_valid,
  input  logic [$clog2(NUM_LREGS)-1:0] wb_lreg,
  input  logic [TAG_W-1:0]             wb_ptag,
  input  logic [PAYLOAD_W-1:0]         wb_value,
  output logic                         src0_imm,
  output logic [TAG_W-1:0]             src0_tag,
  output logic [DATA_W-1:0]            src0_val,
  output logic                         src1_imm,
  output logic [TAG_W-1:0]             src1_tag,
  output logic [DATA_W-1:0]            src1_val,
  output logic                         rel_valid,
  output logic [TAG_W-1:0]             rel_tag
);

  logic                 inl_q [NUM_LREGS];
  logic [PAYLOAD_W-1:0] pay_q [NUM_LREGS];
  logic                 wb_hit;

  function automatic logic [DATA_W-1:0] sext(input logic [PAYLOAD_W-1:0] p);
    return {{(DATA_W-PAYLOAD_W){p[PAYLOAD_W-1]}}, p};
  endfunction

  assign wb_hit = wb_valid && !inl_q[wb_lreg]
               && (pay_q[wb_lreg][TAG_W-1:0] == wb_ptag)
               && !(ren_we && (ren_dst == wb_lreg));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LREGS; i++) begin
        inl_q[i] <= 1'b0;
        pay_q[i] <= PAYLOAD_W'(i);
      end
      rel_valid <= 1'b0;
      rel_tag   <= '0;
    end else begin
      rel_valid <= wb_hit;
      if (wb_hit) begin
        inl_q[wb_lreg] <= 1'b1;
        pay_q[wb_lreg] <= wb_value;
        rel_tag        <= wb_ptag;
      end
      if (ren_we) begin
        inl_q[ren_dst] <= 1'b0;
        pay_q[ren_dst] <= PAYLOAD_W'(ren_tag);
      end
    end
  end

  assign src0_imm = inl_q[ren_src0];
  assign src0_tag = inl_q[ren_src0] ? '0 : pay_q[ren_src0][TAG_W-1:0];
  assign src0_val = inl_q[ren_src0] ? sext(pay_q[ren_src0]) : '0;
  assign src1_imm = inl_q[ren_src1];
  assign src1_tag = inl_q[ren_src1] ? '0 : pay_q[ren_src1][TAG_W-1:0];
  assign src1_val = inl_q[ren_src1] ? sext(pay_q[ren_src1]) : '0;

endmodule

// File: rtl/rename_inline_map_chk.sv
module rename_inline_map_chk #(
  parameter int NUM_LREGS = 32,
  parameter int TAG_W     = 6,
  parameter int PAYLOAD_W = 7,
  parameter int DATA_W    = 32
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [$clog2(NUM_LREGS)-1:0] ren_src0,
  input logic                         ren_we,
  input logic [$clog2(NUM_LREGS)-1:0] ren_dst,
  input logic [TAG_W-1:0]             ren_tag,
  input logic                         wb_valid,
  input logic [$clog2(NUM_LREGS)-1:0] wb_lreg,
  input logic [TAG_W-1:0]             wb_ptag,
  input logic [PAYLOAD_W-1:0]         wb_value,
  input logic                         src0_imm,
  input logic [TAG_W-1:0]             src0_tag,
  input logic [DATA_W-1:0]            src0_val,
  input logic                         rel_valid,
  input logic [TAG_W-1:0]             rel_tag
);

  AST_REL_FROM_WB: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> ($past(wb_valid) && $past(wb_ptag) == rel_tag)); // R10

  AST_RENAME_BEATS_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_we && wb_valid && ren_dst == wb_lreg) |=> !rel_valid); // R9

  AST_RENAME_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ren_we |=> ((ren_src0 != $past(ren_dst)) || (!src0_imm && src0_tag == $past(ren_tag)))); // R2

  AST_INLINE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && ren_src0 == $past(wb_lreg)) |->
      (src0_imm && src0_tag == '0 && src0_val[PAYLOAD_W-1:0] == $past(wb_value))); // R4

  AST_INLINE_SIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    src0_imm |-> (src0_val[DATA_W-1:PAYLOAD_W] == {(DATA_W-PAYLOAD_W){src0_val[PAYLOAD_W-1]}})); // R5

endmodule

bind rename_inline_map rename_inline_map_chk #(
  .NUM_LREGS(NUM_LREGS), .TAG_W(TAG_W), .PAYLOAD_W(PAYLOAD_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ren_src0(ren_src0), .ren_we(ren_we), .ren_dst(ren_dst),
  .ren_tag(ren_tag), .wb_valid(wb_valid), .wb_lreg(wb_lreg), .wb_ptag(wb_ptag),
  .wb_value(wb_value), .src0_imm(src0_imm), .src0_tag(src0_tag), .src0_val(src0_val),
  .rel_valid(rel_valid), .rel_tag(rel_tag)
);

// File: tb/tb_rename_inline_map.sv
module tb_rename_inline_map;

  typedef struct packed {
    logic        imm0;
    logic [5:0]  tag0;
    logic [31:0] val0;
    logic        imm1;
    logic [5:0]  tag1;
    logic [31:0] val1;
    logic        relv;
    logic [5:0]  relt;
  } obs_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] ren_src0 = '0, ren_src1 = '0, ren_dst = '0, wb_lreg = '0;
  logic       ren_we = 1'b0, wb_valid = 1'b0;
  logic [5:0] ren_tag = '0, wb_ptag = '0;
  logic [6:0] wb_value = '0;
  logic        src0_imm, src1_imm, rel_valid;
  logic [5:0]  src0_tag, src1_tag, rel_tag;
  logic [31:0] src0_val, src1_val;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  obs_t  exp_q[$];
  string req_q[$];

  logic       m_inl [32];
  logic [6:0] m_pay [32];
  logic       rel_pend;
  logic [5:0] rel_pend_tag;

  always #5 clk = ~clk;

  rename_inline_map dut (
    .clk(clk), .rst_n(rst_n), .ren_src0(ren_src0), .ren_src1(ren_src1),
    .ren_we(ren_we), .ren_dst(ren_dst), .ren_tag(ren_tag),
    .wb_valid(wb_valid), .wb_lreg(wb_lreg), .wb_ptag(wb_ptag), .wb_value(wb_value),
    .src0_imm(src0_imm), .src0_tag(src0_tag), .src0_val(src0_val),
    .src1_imm(src1_imm), .src1_tag(src1_tag), .src1_val(src1_val),
    .rel_valid(rel_valid), .rel_tag(rel_tag)
  );

  function automatic logic [31:0] ext7(input logic [6:0] p);
    return {{25{p[6]}}, p};
  endfunction

  // Driver: applies one cycle of stimulus and pushes the expected outputs
  task automatic step(input string req, input logic rw, input logic [4:0] d,
                      input logic [5:0] t, input logic [4:0] s0, input logic [4:0] s1,
                      input logic wv, input logic [4:0] wl, input logic [5:0] wp,
                      input logic [6:0] wval);
    obs_t e;
    logic hit;
    @(negedge clk);
    ren_we = rw; ren_dst = d; ren_tag = t; ren_src0 = s0; ren_src1 = s1;
    wb_valid = wv; wb_lreg = wl; wb_ptag = wp; wb_value = wval;
    e.imm0 = m_inl[s0];
    e.tag0 = m_inl[s0] ? 6'd0 : m_pay[s0][5:0];
    e.val0 = m_inl[s0] ? ext7(m_pay[s0]) : 32'd0;
    e.imm1 = m_inl[s1];
    e.tag1 = m_inl[s1] ? 6'd0 : m_pay[s1][5:0];
    e.val1 = m_inl[s1] ? ext7(m_pay[s1]) : 32'd0;
    e.relv = rel_pend;
    e.relt = rel_pend ? rel_pend_tag : 6'd0;
    exp_q.push_back(e);
    req_q.push_back(req);
    hit = wv && !m_inl[wl] && (m_pay[wl][5:0] == wp) && !(rw && d == wl);
    rel_pend = hit;
    rel_pend_tag = wp;
    if (hit) begin m_inl[wl] = 1'b1; m_pay[wl] = wval; end
    if (rw) begin m_inl[d] = 1'b0; m_pay[d] = {1'b0, t}; end
  endtask

  task automatic idle(input string req, input logic [4:0] s0, input logic [4:0] s1);
    step(req, 1'b0, 5'd0, 6'd0, s0, s1, 1'b0, 5'd0, 6'd0, 7'd0);
  endtask

  // Monitor: samples mid-cycle and compares against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() != 0) begin
        obs_t e, a;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        a = {src0_imm, src0_tag, src0_val, src1_imm, src1_tag, src1_val,
             rel_valid, rel_valid ? rel_tag : 6'd0};
        checks++;
        if (a !== e) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", r, a, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all-reqs actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin m_inl[i] = 1'b0; m_pay[i] = 7'(i); end
    rel_pend = 1'b0; rel_pend_tag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 16; i++) idle("R1", 5'(2*i), 5'(2*i+1));

    step("R3", 1'b1, 5'd5, 6'd40, 5'd5, 5'd6, 1'b0, 5'd0, 6'd0, 7'd0);
    idle("R2", 5'd5, 5'd6);

    step("R10", 1'b0, 5'd0, 6'd0, 5'd5, 5'd0, 1'b1, 5'd5, 6'd40, 7'h15);
    idle("R4", 5'd5, 5'd0);
    idle("R10", 5'd5, 5'd0);

    step("R5", 1'b1, 5'd7, 6'd50, 5'd0, 5'd0, 1'b0, 5'd0, 6'd0, 7'd0);
    step("R5", 1'b0, 5'd0, 6'd0, 5'd7, 5'd5, 1'b1, 5'd7, 6'd50, 7'h41);
    idle("R5", 5'd7, 5'd5);

    step("R6", 1'b1, 5'd8, 6'd63, 5'd0, 5'd0, 1'b0, 5'd0, 6'd0, 7'd0);
    idle("R6", 5'd8, 5'd31);

    step("R7", 1'b1, 5'd9, 6'd20, 5'd9, 5'd0, 1'b0, 5'd0, 6'd0, 7'd0);
    step("R7", 1'b1, 5'd9, 6'd21, 5'd9, 5'd0, 1'b0, 5'd0, 6'd0, 7'd0);
    step("R7", 1'b0, 5'd0, 6'd0, 5'd9, 5'd0, 1'b1, 5'd9, 6'd20, 7'h03);
    idle("R7", 5'd9, 5'd0);

    step("R8", 1'b0, 5'd0, 6'd0, 5'd7, 5'd0, 1'b1, 5'd7, 6'd1, 7'h22);
    idle("R8", 5'd7, 5'd0);

    step("R9", 1'b1, 5'd10, 6'd33, 5'd10, 5'd0, 1'b1, 5'd10, 6'd10, 7'h05);
    idle("R9", 5'd10, 5'd0);
    idle("R9", 5'd10, 5'd0);

    step("R11", 1'b1, 5'd5, 6'd12, 5'd5, 5'd0, 1'b0, 5'd0, 6'd0, 7'd0);
    idle("R11", 5'd5, 5'd0);

    for (int n = 0; n < 200; n++) begin
      logic [4:0] d, wl;
      logic [5:0] wp;
      d  = 5'($urandom_range(0, 31));
      wl = 5'($urandom_range(0, 31));
      wp = ($urandom_range(0, 3) != 0) ? m_pay[wl][5:0] : 6'($urandom_range(0, 63));
      step("R4/R7 mix", 1'($urandom_range(0, 1)), d, 6'($urandom_range(0, 63)),
           5'($urandom_range(0, 31)), wl, 1'($urandom_range(0, 1)), wl, wp,
           7'($urandom_range(0, 127)));
    end
    idle("R10", 5'd0, 5'd1);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule